// File: doc/BRIEF.md
# Debug Port Status Sequencer

This block is the serial controller of a development port that sits between an external debug tool and a CPU halted in debug mode. Each serial frame carries a tagged word into the block. The tag marks the word as an instruction or as data. In the same frame the block sends back a two-bit status code and a 32-bit payload. The block holds the received word until the CPU asks for one. It then checks that the kind of word matches the kind of request (instruction fetch or data read). On a match it hands the word over. On a mismatch it ends the CPU read with a bus error.

The block keeps three pending conditions: a sequencing error, valid CPU data waiting to go out, and a CPU interrupt. At the start of every frame it picks the highest-priority condition, reports it, and clears it. A sequencing error comes first, then valid data, then an interrupt. When nothing is pending the status is null. A bus error also marks an interrupt as pending, because the CPU takes an exception. The tool therefore sees the sequencing error first and the interrupt in a later frame. Any word received in a frame that reports an error or an interrupt is thrown away.

The controller is one state machine with four states:
- `S_IDLE` waits for a frame. It moves to `S_SHIFT` when the select line rises.
- `S_SHIFT` moves bits in and out. When the select line falls it goes back to `S_IDLE` if the word is to be dropped, and otherwise to `S_HOLD`.
- `S_HOLD` keeps the received word until the CPU makes a request, then moves to `S_RESP`.
- `S_RESP` raises the one-cycle ready pulse and returns to `S_IDLE`.

Frames are recognised only in `S_IDLE`.

Top module: `dbg_seq_port`

## Requirements
- R1: A frame is the cycles during which `fr_sel` is high, and it contains 34 `fr_shift` strobes. The output carries status[1:0] followed by payload[31:0], MSB first, with the first bit visible on `fr_sdo` in the cycle after the frame starts. Of the input bits, the first is ignored, the second is the type (0 = instruction, 1 = data), and the remaining 32 are the payload, MSB first.
- R2: The status codes are 00 valid data, 01 sequencing error, 10 interrupt occurred and 11 null. Every status other than 00 carries a zero payload.
- R3: After reset nothing is pending, so the first frame returns status 11, and `cpu_rdy` and `cpu_err` are low.
- R4: A `cpu_wvalid` pulse stores `cpu_wdata`. The next frame reports it with status 00 and that data. The stored data is cleared once reported, so the frame after that returns null.
- R5: A held word whose type matches `cpu_kind` (0 = instruction fetch, 1 = data read) is delivered on a pending `cpu_req`. Delivery is a one-cycle `cpu_rdy` with `cpu_err` = 0 and `cpu_rdata` equal to the payload.
- R6: An instruction fetch that meets a data word ends with `cpu_rdy` and `cpu_err` = 1, and `cpu_rdata` = 0.
- R7: A data read that meets an instruction word ends with `cpu_rdy` and `cpu_err` = 1, and `cpu_rdata` = 0.
- R8: After a bus error, the next frame reports 01 and a later frame reports 10. Once both have been reported and nothing else is pending, the next frame returns 11.
- R9: A word shifted in during a frame that reports 01 or 10 is discarded, and a pending CPU request stays unanswered.
- R10: When a sequencing error, valid data and an interrupt are all pending, they are reported in that order, one per frame.
- R11: A `cpu_irq` pulse makes a later frame report 10.
- R12: A `cpu_wvalid` or `cpu_irq` pulse in the same cycle as a frame start does not affect that frame's status. It is reported in the next frame, even when that frame's status just cleared the same condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fr_sel | input | 1 | Frame select, high for the duration of a frame |
| fr_shift | input | 1 | Bit strobe, one bit per cycle in which it is high |
| fr_sdi | input | 1 | Serial data from the debug tool |
| fr_sdo | output | 1 | Serial status and data to the debug tool |
| cpu_req | input | 1 | CPU read request, held until `cpu_rdy` |
| cpu_kind | input | 1 | Kind of request: 0 instruction fetch, 1 data read |
| cpu_rdy | output | 1 | One-cycle read completion |
| cpu_err | output | 1 | Read ended with a bus error |
| cpu_rdata | output | 32 | Word handed to the CPU |
| cpu_wvalid | input | 1 | CPU places data in the port |
| cpu_wdata | input | 32 | Data written by the CPU |
| cpu_irq | input | 1 | CPU interrupt event |

## Verification
A frame start that consumes a pending condition can fall in the same cycle as a CPU write or interrupt that sets the same condition. The bench provokes this by driving `cpu_wvalid` or `cpu_irq` in the exact cycle that `fr_sel` is first seen high. It then judges two frames. The current frame must show the status chosen from the flags as they stood before the event. The following frame must still report the new event, which proves the set was not lost to the clear.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
    typedef enum logic [1:0] {
        ST_VALID  = 2'b00,
        ST_SEQERR = 2'b01,
        ST_INTR   = 2'b10,
        ST_NULL   = 2'b11
    } stat_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SHIFT,
        S_HOLD,
        S_RESP
    } fsm_e;

    localparam logic KIND_INSN = 1'b0;
    localparam logic KIND_DATA = 1'b1;
endpackage

// File: rtl/dbgp_shifter.sv
module dbgp_shifter #(
    parameter int W = 32,
    localparam int OW = W + 2,
    localparam int IW = W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [OW-1:0] load_word,
    input  logic          shift,
    input  logic          sdi,
    output logic          sdo,
    output logic [IW-1:0] in_word
);
    logic [OW-1:0] out_sr;
    logic [IW-1:0] in_sr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sr <= '0;
            in_sr  <= '0;
        end else if (load) begin
            out_sr <= load_word;
        end else if (shift) begin
            out_sr <= {out_sr[OW-2:0], 1'b0};
            in_sr  <= {in_sr[IW-2:0], sdi};
        end
    end

    assign sdo     = out_sr[OW-1];
    assign in_word = in_sr;
endmodule

// File: rtl/dbgp_status_q.sv
module dbgp_status_q
    import dbgp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic         set_seq,
    input  logic         set_int,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    output stat_e        pick_stat,
    output logic [W-1:0] pick_pay
);
    logic         seq_q, dat_q, int_q;
    logic [W-1:0] dat_r;

    always_comb begin
        pick_pay = '0;
        if (seq_q) begin
            pick_stat = ST_SEQERR;
        end else if (dat_q) begin
            pick_stat = ST_VALID;
            pick_pay  = dat_r;
        end else if (int_q) begin
            pick_stat = ST_INTR;
        end else begin
            pick_stat = ST_NULL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= 1'b0;
            dat_q <= 1'b0;
            int_q <= 1'b0;
            dat_r <= '0;
        end else begin
            seq_q <= (seq_q & ~(take & (pick_stat == ST_SEQERR))) | set_seq;
            dat_q <= (dat_q & ~(take & (pick_stat == ST_VALID))) | wr_valid;
            int_q <= (int_q & ~(take & (pick_stat == ST_INTR))) | set_int;
            if (wr_valid) begin
                dat_r <= wr_data;
            end
        end
    end
endmodule

// File: rtl/dbg_seq_port.sv
module dbg_seq_port
    import dbgp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fr_sel,
    input  logic         fr_shift,
    input  logic         fr_sdi,
    output logic         fr_sdo,
    input  logic         cpu_req,
    input  logic         cpu_kind,
    output logic         cpu_rdy,
    output logic         cpu_err,
    output logic [W-1:0] cpu_rdata,
    input  logic         cpu_wvalid,
    input  logic [W-1:0] cpu_wdata,
    input  logic         cpu_irq
);
    localparam int IW = W + 1;

    fsm_e         state_q, state_d;
    stat_e        pick_stat;
    logic [W-1:0] pick_pay;
    logic [IW-1:0] in_word;
    logic         drop_q;
    logic         hold_type;
    logic [W-1:0] hold_pay;
    logic         frame_start, frame_end, mism, bus_err;

    assign frame_start = (state_q == S_IDLE) && fr_sel;
    assign frame_end   = (state_q == S_SHIFT) && !fr_sel;
    assign mism        = (cpu_kind != hold_type);
    assign bus_err     = (state_q == S_HOLD) && cpu_req && mism;

    dbgp_shifter #(.W(W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (frame_start),
        .load_word ({pick_stat, pick_pay}),
        .shift     ((state_q == S_SHIFT) && fr_sel && fr_shift),
        .sdi       (fr_sdi),
        .sdo       (fr_sdo),
        .in_word   (in_word)
    );

    dbgp_status_q #(.W(W)) u_stq (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (frame_start),
        .set_seq   (bus_err),
        .set_int   (bus_err | cpu_irq),
        .wr_valid  (cpu_wvalid),
        .wr_data   (cpu_wdata),
        .pick_stat (pick_stat),
        .pick_pay  (pick_pay)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (fr_sel)  state_d = S_SHIFT;
            S_SHIFT: if (!fr_sel) state_d = drop_q ? S_IDLE : S_HOLD;
            S_HOLD:  if (cpu_req) state_d = S_RESP;
            S_RESP:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and frame bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdy   <= 1'b0;
            cpu_err   <= 1'b0;
            cpu_rdata <= '0;
            drop_q    <= 1'b0;
            hold_type <= KIND_INSN;
            hold_pay  <= '0;
        end else begin
            cpu_rdy <= 1'b0;
            if (frame_start) begin
                drop_q <= (pick_stat == ST_SEQERR) || (pick_stat == ST_INTR);
            end
            if (frame_end && !drop_q) begin
                hold_type <= in_word[IW-1];
                hold_pay  <= in_word[W-1:0];
            end
            if ((state_q == S_HOLD) && cpu_req) begin
                cpu_rdy   <= 1'b1;
                cpu_err   <= mism;
                cpu_rdata <= mism ? '0 : hold_pay;
            end
        end
    end
endmodule

// File: rtl/dbgp_chk.sv
module dbgp_chk
    import dbgp_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cpu_rdy,
    input logic         cpu_err,
    input logic [W-1:0] cpu_rdata,
    input logic         cpu_wvalid,
    input logic         frame_start,
    input logic         frame_end,
    input logic         drop_q,
    input stat_e        pick_stat
);
    logic err_seen, int_due, wr_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_seen <= 1'b0;
            int_due  <= 1'b0;
            wr_seen  <= 1'b0;
        end else begin
            if (cpu_rdy && cpu_err)                   err_seen <= 1'b1;
            else if (frame_start)                     err_seen <= 1'b0;
            if (frame_start && err_seen)              int_due <= 1'b1;
            else if (frame_start)                     int_due <= 1'b0;
            wr_seen <= cpu_wvalid | (wr_seen & ~(frame_start && (pick_stat == ST_VALID)));
        end
    end

    // R5
    rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdy |=> !cpu_rdy);

    // R6
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rdy && cpu_err) |-> (cpu_rdata == '0));

    // R8
    seq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && err_seen) |-> (pick_stat == ST_SEQERR));

    // R8
    int_after_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && int_due) |-> (pick_stat != ST_NULL));

    // R9
    drop_no_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && drop_q) |=> !cpu_rdy);

    // R12
    write_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && wr_seen) |-> (pick_stat != ST_NULL));
endmodule

bind dbg_seq_port dbgp_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_rdy     (cpu_rdy),
    .cpu_err     (cpu_err),
    .cpu_rdata   (cpu_rdata),
    .cpu_wvalid  (cpu_wvalid),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .drop_q      (drop_q),
    .pick_stat   (pick_stat)
);

// File: tb/dbg_seq_port_bench.sv
module dbg_seq_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fr_sel = 0, fr_shift = 0, fr_sdi = 0;
    logic        fr_sdo;
    logic        cpu_req = 0, cpu_kind = 0;
    logic        cpu_rdy, cpu_err;
    logic [31:0] cpu_rdata;
    logic        cpu_wvalid = 0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_irq = 0;

    int total = 0;
    int bad = 0;
    int rdy_cnt = 0;

    logic [33:0] fexp_q[$];
    string       ftag_q[$];
    logic [33:0] fgot;
    logic [32:0] cexp_q[$];
    string       ctag_q[$];
    event        frame_done;

    always #2.5 clk = ~clk;

    dbg_seq_port u_dbg_seq_port (
        .clk(clk), .rst_n(rst_n), .fr_sel(fr_sel), .fr_shift(fr_shift),
        .fr_sdi(fr_sdi), .fr_sdo(fr_sdo), .cpu_req(cpu_req), .cpu_kind(cpu_kind),
        .cpu_rdy(cpu_rdy), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
        .cpu_wvalid(cpu_wvalid), .cpu_wdata(cpu_wdata), .cpu_irq(cpu_irq)
    );

    task automatic check(input string tag, input logic ok,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // frame monitor (scoreboard)
    initial forever begin
        @(frame_done);
        if (fexp_q.size() == 0) begin
            check("frame without expectation", 1'b0, {30'd0, fgot}, 64'd0);
        end else begin
            logic [33:0] e;
            string t;
            e = fexp_q.pop_front();
            t = ftag_q.pop_front();
            check(t, fgot == e, {30'd0, fgot}, {30'd0, e});
        end
    end

    // CPU response monitor (scoreboard)
    always @(negedge clk) begin
        if (rst_n && cpu_rdy) begin
            rdy_cnt++;
            cpu_req = 1'b0;
            if (cexp_q.size() == 0) begin
                check("R9 unexpected cpu_rdy", 1'b0, {31'd0, cpu_err, cpu_rdata}, 64'd0);
            end else begin
                logic [32:0] e;
                string t;
                e = cexp_q.pop_front();
                t = ctag_q.pop_front();
                check(t, {cpu_err, cpu_rdata} == e, {31'd0, cpu_err, cpu_rdata}, {31'd0, e});
            end
        end
    end

    task automatic frame(input logic typ, input logic [31:0] pay,
                         input logic [1:0] es, input logic [31:0] ep, input string tag,
                         input logic sim_wr = 1'b0, input logic [31:0] sim_wd = '0,
                         input logic sim_irq = 1'b0);
        logic [33:0] bits;
        bits = {1'b0, typ, pay};
        fexp_q.push_back({es, ep});
        ftag_q.push_back(tag);
        @(negedge clk);
        fr_sel = 1'b1;
        cpu_wvalid = sim_wr;
        cpu_wdata = sim_wd;
        cpu_irq = sim_irq;
        @(negedge clk);
        cpu_wvalid = 1'b0;
        cpu_irq = 1'b0;
        for (int i = 33; i >= 0; i--) begin
            fgot[i] = fr_sdo;
            fr_sdi = bits[i];
            fr_shift = 1'b1;
            @(negedge clk);
        end
        fr_shift = 1'b0;
        fr_sel = 1'b0;
        -> frame_done;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic req_start(input logic kind, input logic err,
                             input logic [31:0] data, input string tag);
        cexp_q.push_back({err, data});
        ctag_q.push_back(tag);
        @(negedge clk);
        cpu_kind = kind;
        cpu_req = 1'b1;
    endtask

    task automatic wait_rsp();
        while (cpu_req) @(negedge clk);
    endtask

    task automatic cpu_read(input logic kind, input logic err,
                            input logic [31:0] data, input string tag);
        req_start(kind, err, data, tag);
        wait_rsp();
    endtask

    task automatic cpu_write(input logic [31:0] d);
        @(negedge clk);
        cpu_wvalid = 1'b1;
        cpu_wdata = d;
        @(negedge clk);
        cpu_wvalid = 1'b0;
    endtask

    task automatic cpu_int();
        @(negedge clk);
        cpu_irq = 1'b1;
        @(negedge clk);
        cpu_irq = 1'b0;
    endtask

    task automatic no_rdy_check(input string tag);
        int n;
        n = rdy_cnt;
        repeat (4) @(negedge clk);
        check(tag, rdy_cnt == n, 64'(rdy_cnt), 64'(n));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 rdy low after reset", cpu_rdy == 1'b0, {63'd0, cpu_rdy}, 64'd0);
        check("R3 err low after reset", cpu_err == 1'b0, {63'd0, cpu_err}, 64'd0);

        // R1 R3: first frame is null, word forwarded
        frame(1'b0, 32'h1111_1111, 2'b11, 32'h0, "R3 R1 first frame null");
        cpu_read(1'b0, 1'b0, 32'h1111_1111, "R5 instruction delivered");

        // R4 valid data
        cpu_write(32'hDEAD_BEEF);
        frame(1'b1, 32'hA5A5_0F0F, 2'b00, 32'hDEAD_BEEF, "R4 R1 valid data frame");
        cpu_read(1'b1, 1'b0, 32'hA5A5_0F0F, "R5 data delivered");

        // R7 mismatch on data read, then R8 ordering, R9 discards
        req_start(1'b1, 1'b1, 32'h0, "R7 data read meets instruction");
        frame(1'b0, 32'h0000_0002, 2'b11, 32'h0, "R4 R2 cleared after report");
        wait_rsp();
        req_start(1'b0, 1'b0, 32'h3333_3333, "R9 R5 retry gets later word");
        frame(1'b1, 32'hFFFF_FFFF, 2'b01, 32'h0, "R8 R2 seq error first");
        no_rdy_check("R9 word dropped in seq frame");
        frame(1'b0, 32'h1234_5678, 2'b10, 32'h0, "R8 interrupt second");
        no_rdy_check("R9 word dropped in int frame");
        frame(1'b0, 32'h3333_3333, 2'b11, 32'h0, "R8 null after both");
        wait_rsp();

        // R6 mismatch on fetch, R10 priority of three
        req_start(1'b0, 1'b1, 32'h0, "R6 fetch meets data");
        frame(1'b1, 32'h0BAD_F00D, 2'b11, 32'h0, "R6 carrier frame null");
        wait_rsp();
        cpu_write(32'hCAFE_0001);
        frame(1'b0, 32'h0, 2'b01, 32'h0, "R10 seq error first");
        frame(1'b1, 32'h0000_0044, 2'b00, 32'hCAFE_0001, "R10 valid data second");
        cpu_read(1'b1, 1'b0, 32'h0000_0044, "R10 word from data frame");
        frame(1'b0, 32'h0, 2'b10, 32'h0, "R10 interrupt last");
        frame(1'b0, 32'h0000_0055, 2'b11, 32'h0, "R10 null afterwards");
        cpu_read(1'b0, 1'b0, 32'h0000_0055, "R5 fetch after queue drained");

        // R11 external interrupt
        cpu_int();
        frame(1'b1, 32'h0, 2'b10, 32'h0, "R11 interrupt reported");
        frame(1'b1, 32'h0000_0066, 2'b11, 32'h0, "R11 cleared");
        cpu_read(1'b1, 1'b0, 32'h0000_0066, "R11 word after interrupt");

        // R12 same-cycle set and consume
        cpu_int();
        frame(1'b0, 32'h0, 2'b10, 32'h0, "R12 irq in start cycle", 1'b0, 32'h0, 1'b1);
        frame(1'b0, 32'h0, 2'b10, 32'h0, "R12 irq kept for next");
        frame(1'b0, 32'h0000_0077, 2'b11, 32'h0, "R12 null after irq");
        cpu_read(1'b0, 1'b0, 32'h0000_0077, "R12 fetch");
        frame(1'b0, 32'h0000_0088, 2'b11, 32'h0, "R12 write in start cycle",
              1'b1, 32'h600D_CAFE, 1'b0);
        cpu_read(1'b0, 1'b0, 32'h0000_0088, "R12 fetch two");
        frame(1'b1, 32'h0000_0099, 2'b00, 32'h600D_CAFE, "R12 write reported next");
        cpu_read(1'b1, 1'b0, 32'h0000_0099, "R12 data read");

        repeat (4) @(negedge clk);
        check("R5 all responses seen", cexp_q.size() == 0, 64'(cexp_q.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule